// File: doc/BRIEF.md
# CAN Receiver Interrupt Flag Register

This block is the receive-side interrupt status register of a CAN controller. Eight sticky flags record bus events and error-state transitions reported by the protocol engine: a wakeup request seen during sleep, receive and transmit warning levels, receive and transmit error-passive entry, bus-off entry, receive overrun and a filled receive buffer. A host CPU reads the flags through a small register port and clears them one by one by writing ones.

Each flag has a matching enable bit in a second register at its own address. The interrupt request output is high whenever any flag is set together with its enable. A flag can be cleared only once the condition that raised it has gone away. The two warning flags are held back while any error-passive or bus-off flag is already pending. The error counters, bit timing and the bit-stream engine are outside the block. They only feed it counter values and event levels.

Top module: `can_rx_flag_reg`

## Requirements
- R1: The flag register reads at address 0 with bit 7 wakeup, bit 6 receive warning, bit 5 transmit warning, bit 4 receive error-passive, bit 3 transmit error-passive, bit 2 bus-off, bit 1 overrun and bit 0 receive-buffer-full. The enable register, with the same bit positions, is written and read at address 1. Any other address reads 0. Reads have no side effect.
- R2: An active-low asynchronous reset clears all flags and all enables. A synchronous soft reset clears all flags on the next clock edge and leaves the enables unchanged.
- R3: A write to address 0 clears each flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R4: A clear request for a flag is ignored in any cycle in which that flag's set condition is true.
- R5: A flag sets on a rising edge of its set condition. A condition that stays high across a soft reset does not set the flag again until it falls and rises.
- R6: The wakeup flag (bit 7) sets when the sleep indication and bus activity are both high. Either one alone sets nothing.
- R7: The receive warning flag (bit 6) sets when the receive error counter is from 96 to 127 inclusive. This holds only while flags 4, 3 and 2 are all clear.
- R8: The transmit warning flag (bit 5) sets when the transmit error counter is from 96 to 127 inclusive, under the same suppression by flags 4, 3 and 2.
- R9: The receive and transmit error-passive flags set when their counter reaches 128 or more while the bus-off input is low. The bus-off flag sets when the bus-off input rises.
- R10: The overrun flag sets on the overrun event input and the receive-buffer-full flag sets on the buffer-full event input.
- R11: The interrupt output is high exactly when some flag and its enable bit are both 1. It follows the registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset of the flags |
| bus_addr | input | ADDR_W | Register address (0 flags, 1 enables) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| rx_err_cnt | input | CNT_W | Receive error counter value |
| tx_err_cnt | input | CNT_W | Transmit error counter value |
| sleep_mode | input | 1 | Controller is in sleep mode |
| bus_activity | input | 1 | Activity detected on the CAN bus |
| bus_off | input | 1 | Controller is bus-off |
| rx_ovr_evt | input | 1 | Receive overrun condition |
| rx_full_evt | input | 1 | Receive buffer full condition |
| irq | output | 1 | Interrupt request |

## Verification
Every flag result is due one clock edge after the input or write that causes it. The bench drives inputs at the falling edge and samples at the next falling edge, after one rising edge. The interrupt output and read data are combinational from the registers, so they are read in the same window after the address has settled. The asynchronous reset clears the registers at once, so it is checked before any clock edge follows. The soft reset is checked after exactly one edge, and the re-arming rule after a further edge with the condition still held.

// File: rtl/can_rxf_pkg.sv
package can_rxf_pkg;
  localparam int unsigned FLAG_W = 8;

  localparam int unsigned IDX_WAKE  = 7;
  localparam int unsigned IDX_RWARN = 6;
  localparam int unsigned IDX_TWARN = 5;
  localparam int unsigned IDX_RPASS = 4;
  localparam int unsigned IDX_TPASS = 3;
  localparam int unsigned IDX_BOFF  = 2;
  localparam int unsigned IDX_OVR   = 1;
  localparam int unsigned IDX_RFULL = 0;

  typedef logic [FLAG_W-1:0] flag_vec_t;
endpackage

// File: rtl/can_rxf_cond.sv
module can_rxf_cond
  import can_rxf_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned WARN_LO     = 96,
  parameter int unsigned WARN_HI     = 127,
  parameter int unsigned PASSIVE_LIM = 128
) (
  input  logic [CNT_W-1:0] rx_err_cnt,
  input  logic [CNT_W-1:0] tx_err_cnt,
  input  logic             sleep_mode,
  input  logic             bus_activity,
  input  logic             bus_off,
  input  logic             rx_ovr_evt,
  input  logic             rx_full_evt,
  input  flag_vec_t        flags,
  output flag_vec_t        cond
);
  localparam logic [CNT_W-1:0] LO_C   = CNT_W'(WARN_LO);
  localparam logic [CNT_W-1:0] HI_C   = CNT_W'(WARN_HI);
  localparam logic [CNT_W-1:0] PASS_C = CNT_W'(PASSIVE_LIM);

  logic rx_in_win;
  logic tx_in_win;
  logic warn_block;

  always_comb begin
    rx_in_win  = (rx_err_cnt >= LO_C) && (rx_err_cnt <= HI_C);
    tx_in_win  = (tx_err_cnt >= LO_C) && (tx_err_cnt <= HI_C);
    // warnings held back while an error-passive or bus-off flag is pending
    warn_block = flags[IDX_RPASS] | flags[IDX_TPASS] | flags[IDX_BOFF];

    cond            = '0;
    cond[IDX_WAKE]  = sleep_mode & bus_activity;
    cond[IDX_RWARN] = rx_in_win & ~warn_block;
    cond[IDX_TWARN] = tx_in_win & ~warn_block;
    cond[IDX_RPASS] = (rx_err_cnt >= PASS_C) & ~bus_off;
    cond[IDX_TPASS] = (tx_err_cnt >= PASS_C) & ~bus_off;
    cond[IDX_BOFF]  = bus_off;
    cond[IDX_OVR]   = rx_ovr_evt;
    cond[IDX_RFULL] = rx_full_evt;
  end
endmodule

// File: rtl/can_rxf_flag_cell.sv
module can_rxf_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_clr,
  input  logic cond,
  input  logic clr_req,
  output logic flag,
  output logic cond_last
);
  logic cond_q;
  logic flag_q;
  logic rise;
  logic clr_ok;
  logic flag_d;
  logic flag_ce;

  always_comb begin
    rise    = cond & ~cond_q;
    clr_ok  = clr_req & ~cond;
    flag_ce = soft_clr | rise | clr_ok;
    if (soft_clr) begin
      flag_d = 1'b0;
    end else if (rise) begin
      flag_d = 1'b1;
    end else begin
      flag_d = flag_q & ~clr_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cond_q <= 1'b0;
    end else begin
      cond_q <= cond;
      if (flag_ce) begin
        flag_q <= flag_d;
      end
    end
  end

  assign flag      = flag_q;
  assign cond_last = cond_q;
endmodule

// File: rtl/can_rxf_regif.sv
module can_rxf_regif
  import can_rxf_pkg::*;
#(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned FLAG_ADDR = 0,
  parameter int unsigned ENA_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [FLAG_W-1:0] bus_wdata,
  input  flag_vec_t         flags,
  output flag_vec_t         clr_req,
  output flag_vec_t         en,
  output logic [FLAG_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);
  localparam logic [ADDR_W-1:0] ENA_A  = ADDR_W'(ENA_ADDR);

  flag_vec_t en_q;
  flag_vec_t en_d;
  logic      en_ce;
  logic      flag_sel;
  logic      ena_sel;

  always_comb begin
    flag_sel = (bus_addr == FLAG_A);
    ena_sel  = (bus_addr == ENA_A);
    en_ce    = bus_wr & ena_sel;
    en_d     = bus_wdata;
    clr_req  = (bus_wr & flag_sel) ? bus_wdata : '0;
    if (flag_sel) begin
      bus_rdata = flags;
    end else if (ena_sel) begin
      bus_rdata = en_q;
    end else begin
      bus_rdata = '0;
    end
    irq = |(flags & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  assign en = en_q;
endmodule

// File: rtl/can_rx_flag_reg.sv
module can_rx_flag_reg
  import can_rxf_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned WARN_LO     = 96,
  parameter int unsigned WARN_HI     = 127,
  parameter int unsigned PASSIVE_LIM = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [CNT_W-1:0]  rx_err_cnt,
  input  logic [CNT_W-1:0]  tx_err_cnt,
  input  logic              sleep_mode,
  input  logic              bus_activity,
  input  logic              bus_off,
  input  logic              rx_ovr_evt,
  input  logic              rx_full_evt,
  output logic              irq
);
  flag_vec_t flag_q;
  flag_vec_t en_q;
  flag_vec_t cond;
  flag_vec_t cond_q;
  flag_vec_t clr_req;

  can_rxf_cond #(
    .CNT_W      (CNT_W),
    .WARN_LO    (WARN_LO),
    .WARN_HI    (WARN_HI),
    .PASSIVE_LIM(PASSIVE_LIM)
  ) cond_i (
    .rx_err_cnt  (rx_err_cnt),
    .tx_err_cnt  (tx_err_cnt),
    .sleep_mode  (sleep_mode),
    .bus_activity(bus_activity),
    .bus_off     (bus_off),
    .rx_ovr_evt  (rx_ovr_evt),
    .rx_full_evt (rx_full_evt),
    .flags       (flag_q),
    .cond        (cond)
  );

  for (genvar b = 0; b < FLAG_W; b++) begin : g_cell
    can_rxf_flag_cell cell_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_rst),
      .cond     (cond[b]),
      .clr_req  (clr_req[b]),
      .flag     (flag_q[b]),
      .cond_last(cond_q[b])
    );
  end

  can_rxf_regif #(
    .ADDR_W   (ADDR_W),
    .FLAG_ADDR(0),
    .ENA_ADDR (1)
  ) regif_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .flags    (flag_q),
    .clr_req  (clr_req),
    .en       (en_q),
    .bus_rdata(bus_rdata),
    .irq      (irq)
  );
endmodule

// File: rtl/can_rxf_chk.sv
module can_rxf_chk #(
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic              rx_ovr_evt,
  input logic              rx_full_evt,
  input logic              irq,
  input logic [7:0]        flag_q,
  input logic [7:0]        en_q
);
  logic ovr_prev;
  logic flag_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_prev <= 1'b0;
    end else begin
      ovr_prev <= rx_ovr_evt;
    end
  end

  assign flag_wr = bus_wr && (bus_addr == '0);

  // R2
  soft_rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (flag_q == 8'h00));

  // R3
  no_spurious_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !flag_wr) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R4
  clear_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] && rx_full_evt && flag_wr && bus_wdata[0] && !soft_rst) |=> flag_q[0]);

  // R5
  rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovr_evt && !ovr_prev && !soft_rst) |=> flag_q[1]);

  // R7
  rwarn_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q[4] || flag_q[3] || flag_q[2]) && !flag_q[6]) |=> !flag_q[6]);

  // R8
  twarn_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q[4] || flag_q[3] || flag_q[2]) && !flag_q[5]) |=> !flag_q[5]);

  // R11
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((flag_q != 8'h00) && (en_q != 8'h00)));
endmodule

bind can_rx_flag_reg can_rxf_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .rx_ovr_evt (rx_ovr_evt),
  .rx_full_evt(rx_full_evt),
  .irq        (irq),
  .flag_q     (flag_q),
  .en_q       (en_q)
);

// File: tb/can_rx_flag_reg_tb_top.sv
`timescale 1ns/100ps
module can_rx_flag_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       soft_rst;
  logic [1:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [7:0] rx_err_cnt;
  logic [7:0] tx_err_cnt;
  logic       sleep_mode;
  logic       bus_activity;
  logic       bus_off;
  logic       rx_ovr_evt;
  logic       rx_full_evt;
  logic       irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  can_rx_flag_reg dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt),
    .sleep_mode(sleep_mode), .bus_activity(bus_activity), .bus_off(bus_off),
    .rx_ovr_evt(rx_ovr_evt), .rx_full_evt(rx_full_evt), .irq(irq)
  );

  // ev bits: [4] sleep, [3] activity, [2] bus-off, [1] overrun, [0] buffer full
  typedef struct packed {
    logic [4:0] ev;
    logic [7:0] rec;
    logic [7:0] tec;
    logic       wr;
    logic [7:0] wd;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t TBL [NV] = '{
    '{5'b00000, 8'd0,   8'd0,   1'b0, 8'h00, 8'h00},
    '{5'b00001, 8'd0,   8'd0,   1'b0, 8'h00, 8'h01}, // R10
    '{5'b00001, 8'd0,   8'd0,   1'b1, 8'h01, 8'h01}, // R4
    '{5'b00000, 8'd0,   8'd0,   1'b1, 8'h01, 8'h00}, // R3
    '{5'b00010, 8'd0,   8'd0,   1'b0, 8'h00, 8'h02}, // R10
    '{5'b00010, 8'd0,   8'd0,   1'b1, 8'h00, 8'h02}, // R3
    '{5'b00000, 8'd0,   8'd0,   1'b1, 8'hFD, 8'h02}, // R3
    '{5'b00000, 8'd0,   8'd0,   1'b1, 8'h02, 8'h00},
    '{5'b10000, 8'd0,   8'd0,   1'b0, 8'h00, 8'h00}, // R6
    '{5'b01000, 8'd0,   8'd0,   1'b0, 8'h00, 8'h00}, // R6
    '{5'b11000, 8'd0,   8'd0,   1'b0, 8'h00, 8'h80}, // R6
    '{5'b00000, 8'd0,   8'd0,   1'b1, 8'h80, 8'h00},
    '{5'b00000, 8'd95,  8'd0,   1'b0, 8'h00, 8'h00}, // R7
    '{5'b00000, 8'd96,  8'd0,   1'b0, 8'h00, 8'h40}, // R7
    '{5'b00000, 8'd127, 8'd0,   1'b0, 8'h00, 8'h40},
    '{5'b00000, 8'd128, 8'd0,   1'b0, 8'h00, 8'h50}, // R9
    '{5'b00000, 8'd100, 8'd0,   1'b1, 8'h40, 8'h10}, // R7
    '{5'b00000, 8'd100, 8'd0,   1'b1, 8'h10, 8'h00},
    '{5'b00000, 8'd100, 8'd0,   1'b0, 8'h00, 8'h40}, // R7
    '{5'b00000, 8'd0,   8'd0,   1'b1, 8'h40, 8'h00},
    '{5'b00000, 8'd0,   8'd127, 1'b0, 8'h00, 8'h20}, // R8
    '{5'b00000, 8'd0,   8'd200, 1'b0, 8'h00, 8'h28}, // R9
    '{5'b00000, 8'd0,   8'd96,  1'b1, 8'h28, 8'h00}, // R8
    '{5'b00000, 8'd0,   8'd0,   1'b0, 8'h00, 8'h00},
    '{5'b00100, 8'd0,   8'd255, 1'b0, 8'h00, 8'h04}, // R9
    '{5'b00100, 8'd100, 8'd255, 1'b0, 8'h00, 8'h04}, // R7
    '{5'b00000, 8'd0,   8'd0,   1'b1, 8'h04, 8'h00},
    '{5'b00011, 8'd0,   8'd0,   1'b0, 8'h00, 8'h03}, // R10
    '{5'b00000, 8'd0,   8'd0,   1'b1, 8'hFF, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, expv);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // drive at the falling edge, let one rising edge pass, then drop the write
  task automatic step(input logic [4:0] ev, input logic [7:0] rec, input logic [7:0] tec,
                      input logic wr, input logic [1:0] a, input logic [7:0] wd);
    @(negedge clk);
    {sleep_mode, bus_activity, bus_off, rx_ovr_evt, rx_full_evt} = ev;
    rx_err_cnt = rec;
    tx_err_cnt = tec;
    bus_wr     = wr;
    bus_addr   = a;
    bus_wdata  = wd;
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #0.5;
    v = bus_rdata;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] en_m;
    rst_n = 1'b0; soft_rst = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    rx_err_cnt = '0; tx_err_cnt = '0; sleep_mode = 1'b0; bus_activity = 1'b0;
    bus_off = 1'b0; rx_ovr_evt = 1'b0; rx_full_evt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    rd(2'd0, v); check("R2 flags after reset", v, 8'h00);
    rd(2'd1, v); check("R2 enables after reset", v, 8'h00);
    check("R11 irq after reset", {7'd0, irq}, 8'h00);

    // R1 enable access and unused address
    step(5'b0, 8'd0, 8'd0, 1'b1, 2'd1, 8'hA5);
    rd(2'd1, v); check("R1 enable readback", v, 8'hA5);
    rd(2'd1, v); check("R1 second read unchanged", v, 8'hA5);
    rd(2'd2, v); check("R1 unused address", v, 8'h00);

    // R11 masking
    step(5'b0, 8'd0, 8'd0, 1'b1, 2'd1, 8'h02);
    step(5'b00001, 8'd0, 8'd0, 1'b0, 2'd0, 8'h00);
    rd(2'd0, v); check("R10 full flag", v, 8'h01);
    check("R11 irq masked", {7'd0, irq}, 8'h00);
    step(5'b00000, 8'd0, 8'd0, 1'b1, 2'd1, 8'h01);
    check("R11 irq enabled", {7'd0, irq}, 8'h01);
    step(5'b00000, 8'd0, 8'd0, 1'b1, 2'd0, 8'h01);
    check("R11 irq after clear", {7'd0, irq}, 8'h00);

    // table walk with all enables on
    step(5'b0, 8'd0, 8'd0, 1'b1, 2'd1, 8'hFF);
    en_m = 8'hFF;
    for (int i = 0; i < NV; i++) begin
      step(TBL[i].ev, TBL[i].rec, TBL[i].tec, TBL[i].wr, 2'd0, TBL[i].wd);
      rd(2'd0, v);
      check($sformatf("R1 table vector %0d flags", i), v, TBL[i].exp);
      check($sformatf("R11 table vector %0d irq", i), {7'd0, irq}, {7'd0, |(TBL[i].exp & en_m)});
    end

    // R2 / R5 soft reset with a held condition
    step(5'b00010, 8'd0, 8'd0, 1'b0, 2'd0, 8'h00);
    rd(2'd0, v); check("R10 overrun set", v, 8'h02);
    @(negedge clk); soft_rst = 1'b1;
    @(posedge clk); #1; soft_rst = 1'b0;
    rd(2'd0, v); check("R2 soft reset clears flags", v, 8'h00);
    rd(2'd1, v); check("R2 soft reset keeps enables", v, 8'hFF);
    step(5'b00010, 8'd0, 8'd0, 1'b0, 2'd0, 8'h00);
    rd(2'd0, v); check("R5 held condition no re-set", v, 8'h00);
    step(5'b00000, 8'd0, 8'd0, 1'b0, 2'd0, 8'h00);
    step(5'b00010, 8'd0, 8'd0, 1'b0, 2'd0, 8'h00);
    rd(2'd0, v); check("R5 new rising edge sets", v, 8'h02);

    // R2 asynchronous hard reset
    @(negedge clk); rst_n = 1'b0;
    #0.5;
    rd(2'd0, v); check("R2 hard reset flags", v, 8'h00);
    rd(2'd1, v); check("R2 hard reset enables", v, 8'h00);
    check("R11 irq in reset", {7'd0, irq}, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    summary();
  end
endmodule